// File: doc/BRIEF.md
# Sample-to-Word Packer

This block takes a stream of samples that are 8, 16 or 32 bits wide and gathers them into 32-bit words ready to be written to memory. Each accepted sample fills one, two or four byte lanes of the word being built. The earliest sample of a word always lands in the lowest lane. A word is emitted as soon as all four lanes are full.

A global endian input sets the byte order inside each 16-bit or 32-bit sample. 8-bit samples ignore this input. At the end of a record or message, a flush request pushes out a partly filled word with its empty lanes cleared to zero, so the next sample starts a fresh word. The size select is sampled only while no partial word is held, so a size change part-way through a word does not corrupt it.

Top module: `sample_packer`

## Requirements
- R1: The size-select field is decoded as 2'b00 = 8-bit, 2'b01 = 16-bit, and 2'b10 or 2'b11 = 32-bit. Only the low 8 or 16 bits of the sample bus are used for 8-bit or 16-bit samples, and the upper bits have no effect on the output word.
- R2: With 32-bit samples in little-endian mode, every accepted sample is emitted unchanged as one word. The word appears on the clock edge after the sample is accepted.
- R3: With 8-bit samples, four consecutive samples form one word. The first goes in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24]. The word is emitted one cycle after the fourth sample.
- R4: With 16-bit samples, two consecutive samples form one word. The first goes in bits [15:0] and the second in [31:16].
- R5: With bigEndian high and 16-bit samples, the two bytes of each sample are exchanged inside its own half of the word.
- R6: With bigEndian high and 32-bit samples, the four bytes of the sample are reversed (bits [7:0] go to [31:24], and so on).
- R7: 8-bit samples are placed in arrival order whatever the value of bigEndian.
- R8: A flush request while a partial word is held emits that word one cycle later, with unfilled lanes at zero. The next sample then starts at bits [7:0].
- R9: A flush request that arrives in the same cycle as a sample includes that sample in the emitted word. A flush request with no sample and no partial word produces no output.
- R10: The size select is ignored while a partial word is held. Samples keep the size in force when the word was started, and a new size applies only once the word has been emitted.
- R11: After reset, wordValid and wordData are zero and no partial word is held.
- R12: wordValid is high for exactly one cycle per emitted word and is low in any cycle that follows a cycle with neither a sample nor a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Sample present on sampleData this cycle |
| sampleData | input | 32 | Sample bus, low bits used for narrow sizes |
| sizeSel | input | 2 | Sample size: 00 = 8-bit, 01 = 16-bit, 1x = 32-bit |
| bigEndian | input | 1 | Byte order inside 16-bit and 32-bit samples |
| flushReq | input | 1 | Emit any partial word at record or message end |
| wordValid | output | 1 | One-cycle pulse marking a packed word |
| wordData | output | 32 | Packed word |

## Verification
The hardest case to reach from the ports is a size change that arrives while a partial word is held. It needs a word opened at one size, followed by samples that carry a different size code but must still be packed at the original width. The bench starts an 8-bit word and then sends samples tagged 32-bit, with non-zero upper bits that would show up if they were wrongly taken as wide samples. It then checks that the next word is packed at the new size. Flush timing is also exercised: one flush on its own, one flush that coincides with a sample, and one flush on an empty packer.

// File: rtl/sample_packer_pkg.sv
`timescale 1ns/1ps
package sample_packer_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = BYTE_W * LANES;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } sampleSize_e;

  typedef struct packed {
    logic              accept;
    logic              emit;
    logic [LANE_W-1:0] lane;
    sampleSize_e       size;
  } packStrobe_t;

  function automatic sampleSize_e sizeDecode(input logic [1:0] code);
    case (code)
      2'b00:   return SZ_BYTE;
      2'b01:   return SZ_HALF;
      default: return SZ_WORD;
    endcase
  endfunction

  function automatic logic [LANE_W:0] sizeBytes(input sampleSize_e sz);
    case (sz)
      SZ_BYTE: return (LANE_W+1)'(1);
      SZ_HALF: return (LANE_W+1)'(2);
      default: return (LANE_W+1)'(LANES);
    endcase
  endfunction
endpackage

// File: rtl/sample_packer_ctrl.sv
`timescale 1ns/1ps
module sample_packer_ctrl
  import sample_packer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [1:0]        sizeSel,
  input  logic              flushReq,
  output packStrobe_t       strobe,
  output logic [LANE_W-1:0] fillLane,
  output sampleSize_e       heldSize
);
  logic          isEmpty;
  sampleSize_e   effSize;
  logic [LANE_W:0] nextFill;
  logic          complete;
  logic          emit;

  assign isEmpty  = (fillLane == '0);
  assign effSize  = isEmpty ? sizeDecode(sizeSel) : heldSize;
  assign nextFill = {1'b0, fillLane} + sizeBytes(effSize);
  assign complete = nextFill[LANE_W];
  assign emit     = (sampleValid && complete) || (flushReq && (sampleValid || !isEmpty));

  always_comb begin
    strobe.accept = sampleValid;
    strobe.emit   = emit;
    strobe.lane   = fillLane;
    strobe.size   = effSize;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillLane <= '0;
      heldSize <= SZ_BYTE;
    end else begin
      if (emit)             fillLane <= '0;
      else if (sampleValid) fillLane <= nextFill[LANE_W-1:0];
      if (sampleValid && isEmpty) heldSize <= effSize;
    end
  end
endmodule

// File: rtl/sample_packer_dp.sv
`timescale 1ns/1ps
module sample_packer_dp
  import sample_packer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  packStrobe_t       strobe,
  input  logic              bigEndian,
  input  logic [WORD_W-1:0] sampleData,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData
);
  logic [LANES-1:0][BYTE_W-1:0] sampleBytes;
  logic [LANES-1:0][BYTE_W-1:0] orderedBytes;
  logic [LANES-1:0][BYTE_W-1:0] accBytes;
  logic [LANES-1:0][BYTE_W-1:0] mergedBytes;
  logic [LANE_W:0]              width;
  logic                         doSwap;

  assign sampleBytes = sampleData;
  assign width       = sizeBytes(strobe.size);
  assign doSwap      = bigEndian && (strobe.size != SZ_BYTE);

  for (genvar j = 0; j < LANES; j++) begin : g_order
    localparam logic [LANE_W:0] JIDX = (LANE_W+1)'(j);
    logic [LANE_W:0] srcIdx;
    assign srcIdx = width - JIDX - (LANE_W+1)'(1);
    assign orderedBytes[j] = (JIDX >= width) ? '0 :
                             (doSwap ? sampleBytes[srcIdx[LANE_W-1:0]] : sampleBytes[j]);
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam logic [LANE_W:0] BIDX = (LANE_W+1)'(b);
    logic [LANE_W:0] rel;
    logic            hit;
    assign rel = BIDX - {1'b0, strobe.lane};
    assign hit = strobe.accept && (BIDX >= {1'b0, strobe.lane}) && (rel < width);
    assign mergedBytes[b] = hit ? orderedBytes[rel[LANE_W-1:0]] : accBytes[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accBytes  <= '0;
      wordData  <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strobe.emit;
      if (strobe.emit) begin
        wordData <= mergedBytes;
        accBytes <= '0;
      end else if (strobe.accept) begin
        accBytes <= mergedBytes;
      end
    end
  end
endmodule

// File: rtl/sample_packer.sv
`timescale 1ns/1ps
module sample_packer
  import sample_packer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic [31:0] sampleData,
  input  logic [1:0]  sizeSel,
  input  logic        bigEndian,
  input  logic        flushReq,
  output logic        wordValid,
  output logic [31:0] wordData
);
  packStrobe_t       strobe;
  logic [LANE_W-1:0] fillLane;
  sampleSize_e       heldSize;

  sample_packer_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sizeSel    (sizeSel),
    .flushReq   (flushReq),
    .strobe     (strobe),
    .fillLane   (fillLane),
    .heldSize   (heldSize)
  );

  sample_packer_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bigEndian (bigEndian),
    .sampleData(sampleData),
    .wordValid (wordValid),
    .wordData  (wordData)
  );
endmodule

// File: rtl/sample_packer_chk.sv
`timescale 1ns/1ps
module sample_packer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        sampleValid,
  input logic [31:0] sampleData,
  input logic [1:0]  sizeSel,
  input logic        bigEndian,
  input logic        flushReq,
  input logic        wordValid,
  input logic [31:0] wordData,
  input logic [1:0]  fillLane,
  input logic [1:0]  heldSize
);
  AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && fillLane == 2'd0 && sizeSel[1] && !bigEndian)
      |=> (wordValid && wordData == $past(sampleData))); // R2

  AST_WORD_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && fillLane == 2'd0 && sizeSel[1] && bigEndian)
      |=> (wordValid && wordData == {$past(sampleData[7:0]), $past(sampleData[15:8]),
                                     $past(sampleData[23:16]), $past(sampleData[31:24])})); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && fillLane == 2'd0) |=> !wordValid); // R9

  AST_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (fillLane != 2'd0) |=> $stable(heldSize)); // R10

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(sampleValid || flushReq)); // R12
endmodule

bind sample_packer sample_packer_chk chk_i (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
  .sizeSel(sizeSel), .bigEndian(bigEndian), .flushReq(flushReq),
  .wordValid(wordValid), .wordData(wordData), .fillLane(fillLane), .heldSize(heldSize)
);

// File: tb/sample_packer_tb_top.sv
`timescale 1ns/1ps
module sample_packer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [31:0] sampleData = '0;
  logic [1:0]  sizeSel = 2'b00;
  logic        bigEndian = 1'b0;
  logic        flushReq = 1'b0;
  logic        wordValid;
  logic [31:0] wordData;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  sample_packer dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .sizeSel(sizeSel), .bigEndian(bigEndian), .flushReq(flushReq),
    .wordValid(wordValid), .wordData(wordData)
  );

  // Drive one cycle of inputs, then look at outputs 2 ns after the edge.
  task automatic step(input logic v, input logic [31:0] d, input logic [1:0] sz,
                      input logic be, input logic fl);
    sampleValid = v; sampleData = d; sizeSel = sz; bigEndian = be; flushReq = fl;
    @(posedge clk);
    #2;
    sampleValid = 1'b0; flushReq = 1'b0;
  endtask

  task automatic expectWord(input logic [31:0] exp, input string tag);
    checks++;
    if (!wordValid || wordData !== exp) begin
      failures++;
      $display("FAIL %s: valid=%0b data=%08h expected valid=1 data=%08h", tag, wordValid, wordData, exp);
    end
  endtask

  task automatic expectNone(input string tag);
    checks++;
    if (wordValid !== 1'b0) begin
      failures++;
      $display("FAIL %s: valid=%0b expected valid=0", tag, wordValid);
    end
  endtask

  task automatic testReset();
    checks++;
    if (wordValid !== 1'b0 || wordData !== 32'h0) begin
      failures++;
      $display("FAIL R11: valid=%0b data=%08h expected 0/00000000", wordValid, wordData);
    end
  endtask

  task automatic testWord();
    step(1, 32'hA1B2C3D4, 2'b10, 0, 0); expectWord(32'hA1B2C3D4, "R2 32-bit LE");
    step(1, 32'h0F1E2D3C, 2'b11, 0, 0); expectWord(32'h0F1E2D3C, "R1 code 11 as 32-bit");
    step(1, 32'hA1B2C3D4, 2'b10, 1, 0); expectWord(32'hD4C3B2A1, "R6 32-bit BE");
    step(0, 32'h0, 2'b10, 0, 0);        expectNone("R12 single pulse");
  endtask

  task automatic testByte(input logic be, input string tag);
    step(1, 32'hFFFFFF11, 2'b00, be, 0); expectNone(tag);
    step(1, 32'hEEEEEE22, 2'b00, be, 0); expectNone(tag);
    step(1, 32'hDDDDDD33, 2'b00, be, 0); expectNone(tag);
    step(1, 32'hCCCCCC44, 2'b00, be, 0); expectWord(32'h44332211, tag);
  endtask

  task automatic testHalf();
    step(1, 32'hDEAD1234, 2'b01, 0, 0); expectNone("R4 first half");
    step(1, 32'hBEEF5678, 2'b01, 0, 0); expectWord(32'h56781234, "R4 16-bit LE");
    step(1, 32'hDEAD1234, 2'b01, 1, 0); expectNone("R5 first half");
    step(1, 32'hBEEF5678, 2'b01, 1, 0); expectWord(32'h78563412, "R5 16-bit BE");
  endtask

  task automatic testFlush();
    step(1, 32'h00000011, 2'b00, 0, 0);
    step(1, 32'h00000022, 2'b00, 0, 0); expectNone("R8 partial held");
    step(0, 32'h0, 2'b00, 0, 1);        expectWord(32'h00002211, "R8 flush partial");
    testByte(0, "R8 restart at lane 0");
    step(1, 32'h000000AA, 2'b00, 0, 0);
    step(1, 32'h000000BB, 2'b00, 0, 1); expectWord(32'h0000BBAA, "R9 flush with sample");
    step(0, 32'h0, 2'b00, 0, 1);        expectNone("R9 flush when empty");
    step(1, 32'h0000CAFE, 2'b01, 1, 1); expectWord(32'h0000FECA, "R9 lone half flush");
  endtask

  task automatic testSizeChange();
    step(1, 32'h00000011, 2'b00, 0, 0);
    step(1, 32'h99999922, 2'b10, 0, 0); expectNone("R10 size ignored mid-word");
    step(1, 32'h88888833, 2'b01, 0, 0); expectNone("R10 size ignored mid-word");
    step(1, 32'h77777744, 2'b10, 0, 0); expectWord(32'h44332211, "R10 word kept 8-bit");
    step(1, 32'h12345678, 2'b10, 0, 0); expectWord(32'h12345678, "R10 new size applies");
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    testReset();
    rstN = 1'b1;
    testWord();
    testByte(0, "R3 8-bit LE");
    testByte(1, "R7 8-bit ignores BE");
    testHalf();
    testFlush();
    testSizeChange();
    step(0, 32'h0, 2'b00, 0, 0); expectNone("R12 idle after word");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule